// File: doc/BRIEF.md
# Banked Instruction ROM Selector

This block widens the program space of a small 8-bit soft processor whose instruction address is only 10 bits wide. Three separate 1K-word ROMs of 18-bit instructions sit behind it, giving 3K words in total. The block passes the processor's fetch address to one ROM, the active bank. It holds the address of the other two ROMs at 0x3FF. It returns the active bank's word as the fetched instruction.

The active bank is chosen by a 2-bit select register. Software loads it by writing to a dedicated output port. The new bank already supplies the fetch that follows that write. Fetching carries on in address order across a switch, so every bank keeps the same switch code at the same addresses. The switch takes four instructions: load the select value, output it, a harmless filler, then a jump to the entry point in the new bank.

Select encoding: 2'b00 picks bank 0, 2'b01 picks bank 1, 2'b10 picks bank 2, and 2'b11 is reserved. Under the reserved code every bank is parked and the processor receives the filler word.

Top module: `brom_bank_selector`

## Requirements
- R1: A clock edge with `rst_n` low clears the select register to 2'b00. From then on bank 0 receives `fetch_addr` and supplies `fetch_instr`.
- R2: A clock edge with `port_wr` high and `port_id` equal to the select port ID (default 8'h05) loads `port_data[1:0]` into the select register. The next fetch is served from the bank selected by the new value.
- R3: A port write to any other port ID leaves the active bank unchanged.
- R4: With `port_wr` low, a matching `port_id` and any data leave the active bank unchanged.
- R5: The active bank's address lane carries `fetch_addr` combinationally. Each inactive bank's lane carries 10'h3FF. Lane k occupies bits [10k+9:10k] of `rom_addr`.
- R6: For select values 00, 01 and 10, `fetch_instr` equals the 18-bit word on the active bank's data lane. Lane k occupies bits [18k+17:18k] of `rom_data`.
- R7: With the reserved select value 2'b11, all three address lanes carry 10'h3FF and `fetch_instr` is the filler word (default 18'h0A000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | 10 | Processor instruction address |
| fetch_instr | output | 18 | Instruction word returned to the processor |
| port_id | input | 8 | Processor output port ID |
| port_wr | input | 1 | Processor output write strobe |
| port_data | input | 2 | Low two bits of the processor output data |
| rom_addr | output | 30 | Address lanes to the three ROMs, lane k at [10k+9:10k] |
| rom_data | input | 54 | Data lanes from the three ROMs, lane k at [18k+17:18k] |

## Verification
The only state in this block is the select register. A wrong value in it shows up in the same cycle it appears: a different address lane follows the fetch address, and the returned word carries another bank's tag. The bench gives each bank's ROM model a distinct, address-derived word. A write that is missed, lands late or lands spuriously therefore shows up on the very next fetch after the write edge. Reset clearing and the reserved code are checked the same way, through the lanes and the returned word.

// File: rtl/brom_pkg.sv
// Package: shared constants and select encodings for the banked ROM selector.
// Assumes exactly three banks addressed by a 2-bit select code.
package brom_pkg;
    localparam int BANK_COUNT = 3;
    localparam int SEL_W      = 2;

    localparam logic [SEL_W-1:0] SEL_BANK0 = 2'b00;
    localparam logic [SEL_W-1:0] SEL_BANK1 = 2'b01;
    localparam logic [SEL_W-1:0] SEL_BANK2 = 2'b10;
    localparam logic [SEL_W-1:0] SEL_RSVD  = 2'b11;
endpackage

// File: rtl/brom_sel_reg.sv
// Module: bank select register with output-port decode.
// Loads the select code when the processor writes the designated port ID.
// Assumes the write strobe is a single-cycle pulse, synchronous to clk.
module brom_sel_reg
    import brom_pkg::*;
#(
    parameter int          PORT_W      = 8,
    parameter logic [PORT_W-1:0] SEL_PORT_ID = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_id,
    input  logic              port_wr,
    input  logic [SEL_W-1:0]  port_data,
    output logic [SEL_W-1:0]  sel_q
);
    logic hit;

    // Port decode: a write aimed at the select port.
    always_comb hit = port_wr && (port_id == SEL_PORT_ID);

    // Select register: clear on reset, load on a decoded write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   sel_q <= SEL_BANK0;
        else if (hit) sel_q <= port_data;
    end

    // R1
    sel_reset_clear_chk: assert property (@(posedge clk) !rst_n |=> sel_q == SEL_BANK0);
    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_id == SEL_PORT_ID) |=> sel_q == $past(port_data));
    // R3 R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && port_id == SEL_PORT_ID) |=> $stable(sel_q));
endmodule

// File: rtl/brom_addr_route.sv
// Module: address router. The active bank gets the fetch address; every
// other bank is parked at PARK_ADDR. Purely combinational.
module brom_addr_route
    import brom_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NBANK  = BANK_COUNT,
    parameter logic [ADDR_W-1:0] PARK_ADDR = '1
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [ADDR_W-1:0]       fetch_addr,
    output logic [NBANK*ADDR_W-1:0] rom_addr
);
    for (genvar k = 0; k < NBANK; k++) begin : g_lane
        // Lane k: follow the fetch address only while bank k is active.
        assign rom_addr[k*ADDR_W +: ADDR_W] =
            (sel == SEL_W'(k)) ? fetch_addr : PARK_ADDR;
    end
endmodule

// File: rtl/brom_instr_mux.sv
// Module: instruction return multiplexer. Picks the active bank's data
// lane; a reserved select value yields the filler word.
module brom_instr_mux
    import brom_pkg::*;
#(
    parameter int INSTR_W = 18,
    parameter int NBANK   = BANK_COUNT,
    parameter logic [INSTR_W-1:0] FILLER = 18'h0A000
) (
    input  logic [SEL_W-1:0]         sel,
    input  logic [NBANK*INSTR_W-1:0] rom_data,
    output logic [INSTR_W-1:0]       instr
);
    // Return path: default to the filler, override with the matching lane.
    always_comb begin
        instr = FILLER;
        for (int k = 0; k < NBANK; k++) begin
            if (sel == SEL_W'(k)) instr = rom_data[k*INSTR_W +: INSTR_W];
        end
    end
endmodule

// File: rtl/brom_bank_selector.sv
// Module: banked instruction ROM selector (top).
// Extends a 10-bit fetch address to three 1K banks. Assumes the ROMs
// return data combinationally for the address on their lane and that the
// processor keeps switch code aligned across banks.
module brom_bank_selector
    import brom_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int INSTR_W = 18,
    parameter int PORT_W  = 8,
    parameter logic [PORT_W-1:0]  SEL_PORT_ID = 8'h05,
    parameter logic [INSTR_W-1:0] FILLER      = 18'h0A000,
    localparam int NBANK = BANK_COUNT,
    localparam logic [ADDR_W-1:0] PARK_ADDR = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         fetch_addr,
    output logic [INSTR_W-1:0]        fetch_instr,
    input  logic [PORT_W-1:0]         port_id,
    input  logic                      port_wr,
    input  logic [SEL_W-1:0]          port_data,
    output logic [NBANK*ADDR_W-1:0]   rom_addr,
    input  logic [NBANK*INSTR_W-1:0]  rom_data
);
    logic [SEL_W-1:0] sel;
    logic [NBANK-1:0] lane_live;

    brom_sel_reg #(.PORT_W(PORT_W), .SEL_PORT_ID(SEL_PORT_ID)) u_sel (
        .clk(clk), .rst_n(rst_n), .port_id(port_id),
        .port_wr(port_wr), .port_data(port_data), .sel_q(sel)
    );

    brom_addr_route #(.ADDR_W(ADDR_W), .NBANK(NBANK), .PARK_ADDR(PARK_ADDR)) u_route (
        .sel(sel), .fetch_addr(fetch_addr), .rom_addr(rom_addr)
    );

    brom_instr_mux #(.INSTR_W(INSTR_W), .NBANK(NBANK), .FILLER(FILLER)) u_mux (
        .sel(sel), .rom_data(rom_data), .instr(fetch_instr)
    );

    // Checker view: which lanes currently carry a non-parked address.
    always_comb begin
        for (int k = 0; k < NBANK; k++)
            lane_live[k] = (rom_addr[k*ADDR_W +: ADDR_W] != PARK_ADDR);
    end

    // R5
    one_lane_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_live) <= 1);
    // R5
    active_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_RSVD) |-> rom_addr[sel*ADDR_W +: ADDR_W] == fetch_addr);
    // R6
    instr_from_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_RSVD) |-> fetch_instr == rom_data[sel*INSTR_W +: INSTR_W]);
    // R7
    rsvd_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_RSVD) |-> (lane_live == '0 && fetch_instr == FILLER));
endmodule

// File: tb/test_brom_bank_selector.sv
// Bench: scoreboard. The driver applies a stimulus and pushes the expected
// lanes and instruction; the monitor pops and compares at the falling edge.
module test_brom_bank_selector;
    typedef struct {
        logic [29:0] exp_addr;
        logic [17:0] exp_instr;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  fetch_addr = '0;
    logic [17:0] fetch_instr;
    logic [7:0]  port_id = '0;
    logic        port_wr = 1'b0;
    logic [1:0]  port_data = '0;
    logic [29:0] rom_addr;
    logic [53:0] rom_data;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    item_t sb[$];
    logic [1:0] m_sel = 2'b00;

    localparam logic [17:0] FILL = 18'h0A000;

    always #5 clk = ~clk;

    brom_bank_selector i_brom_bank_selector (
        .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .fetch_instr(fetch_instr),
        .port_id(port_id), .port_wr(port_wr), .port_data(port_data),
        .rom_addr(rom_addr), .rom_data(rom_data)
    );

    // ROM models: a distinct word per bank and address.
    function automatic logic [17:0] rom_word(int b, logic [9:0] a);
        return {2'(b + 1), 6'(b * 7 + 3), a};
    endfunction

    always_comb begin
        for (int k = 0; k < 3; k++)
            rom_data[k*18 +: 18] = rom_word(k, rom_addr[k*10 +: 10]);
    end

    // Expected lanes and word for a given select and address.
    function automatic item_t expect_for(logic [1:0] s, logic [9:0] a, string req);
        item_t it;
        it.req = req;
        it.exp_instr = (s == 2'b11) ? FILL : rom_word(int'(s), a);
        for (int k = 0; k < 3; k++)
            it.exp_addr[k*10 +: 10] = (s == 2'(k)) ? a : 10'h3FF;
        return it;
    endfunction

    // Driver: apply one cycle of stimulus, push the expectation for it.
    task automatic step(logic [9:0] a, logic [7:0] id, logic wr, logic [1:0] d, string req);
        @(posedge clk);
        #1;
        fetch_addr = a; port_id = id; port_wr = wr; port_data = d;
        sb.push_back(expect_for(m_sel, a, req));
        if (wr && id == 8'h05 && rst_n) m_sel = d;
    endtask

    task automatic sync_reset(string req);
        @(posedge clk);
        #1;
        rst_n = 1'b0; port_wr = 1'b0;
        m_sel = 2'b00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        sb.push_back(expect_for(m_sel, fetch_addr, req));
    endtask

    // Monitor: compare pending expectations away from the active edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rom_addr !== it.exp_addr || fetch_instr !== it.exp_instr) begin
                failures++;
                $display("FAIL %s addr=%h exp_addr=%h instr=%h exp_instr=%h",
                         it.req, rom_addr, it.exp_addr, fetch_instr, it.exp_instr);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state: bank 0 active
        sb.push_back(expect_for(2'b00, 10'h000, "R1"));
        step(10'h000, 8'h00, 1'b0, 2'b00, "R1");
        step(10'h3FE, 8'h00, 1'b0, 2'b00, "R5");
        step(10'h155, 8'h00, 1'b0, 2'b00, "R6");
        // R2 switch to bank 1, fetch after write from bank 1
        step(10'h3EE, 8'h05, 1'b1, 2'b01, "R2");
        step(10'h3EF, 8'h00, 1'b0, 2'b00, "R2");
        step(10'h2AA, 8'h00, 1'b0, 2'b00, "R6");
        // R3 other port ID ignored
        step(10'h010, 8'h04, 1'b1, 2'b10, "R3");
        step(10'h011, 8'h85, 1'b1, 2'b00, "R3");
        step(10'h012, 8'h00, 1'b0, 2'b00, "R3");
        // R4 strobe low ignored
        step(10'h020, 8'h05, 1'b0, 2'b10, "R4");
        step(10'h021, 8'h05, 1'b0, 2'b00, "R4");
        // R2 switch to bank 2
        step(10'h3E8, 8'h05, 1'b1, 2'b10, "R2");
        step(10'h3E9, 8'h00, 1'b0, 2'b00, "R5");
        step(10'h3FF, 8'h00, 1'b0, 2'b00, "R6");
        // R7 reserved code: all parked, filler returned
        step(10'h100, 8'h05, 1'b1, 2'b11, "R7");
        step(10'h101, 8'h00, 1'b0, 2'b00, "R7");
        step(10'h000, 8'h00, 1'b0, 2'b00, "R7");
        // R2 back to bank 0, then bank 1 again
        step(10'h200, 8'h05, 1'b1, 2'b00, "R2");
        step(10'h201, 8'h05, 1'b1, 2'b01, "R2");
        step(10'h202, 8'h00, 1'b0, 2'b00, "R5");
        // R1 mid-run reset returns to bank 0
        sync_reset("R1");
        step(10'h0F0, 8'h00, 1'b0, 2'b00, "R1");
        step(10'h0F1, 8'h00, 1'b0, 2'b00, "R6");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule